// File: doc/BRIEF.md
# Parallel Panel Command/Data Bus Engine

This block lets software talk to a command-mode display panel over a parallel system bus that is 8 to 18 bits wide. Software first stores a word in the block. The word holds a payload in its low bits, a validity flag, and a flag that chooses between an index (command) cycle and a data cycle. Software then writes a trigger register. The trigger starts the bus cycle and picks either the main panel or the sub panel.

The engine runs one bus access. It asserts the selected chip select, drives register-select, pulses the write or read strobe, and then releases everything. The lengths of the setup, strobe and hold phases are fixed by parameters. A busy flag in the status register stays high for the whole access, so software can poll it.

A read uses a second pair of registers. Software writes the read-data register to choose index or data, then writes the read trigger. The value on the panel bus at the end of the read strobe is captured. It is returned in the low 18 bits of the read-data register, and the upper bits read as zero.

Top module: `pbus_cmd_engine`

## Requirements
- R1: After reset, both chip selects (`pnl_cs_n`, active low) and both strobes (`pnl_wr_n`, `pnl_rd_n`, active low) are high. The bus is not driven. Status bit 1 reads 0, and the read-data register (address 2) reads 0.
- R2: The write word is at address 0. Its bit 28 is the valid flag. A write trigger is ignored while this bit is 0, and no chip select or strobe moves.
- R3: A write to the write trigger (address 1) with bit 0 set starts a write cycle. Bit 1 of that write selects the sub panel (`pnl_cs_n[1]`) when 1 and the main panel (`pnl_cs_n[0]`) when 0. The other chip select stays high for the whole cycle. A trigger with bit 0 clear does nothing.
- R4: `pnl_rs` follows bit 24 of the stored word (0 = index, 1 = data) for every cycle in which the chip select is low. It does not change while the chip select stays low.
- R5: A write cycle holds the chip select low for SETUP_CYC clocks before the strobe. It then holds `pnl_wr_n` low for STROBE_CYC clocks, and keeps the chip select low for HOLD_CYC clocks after the strobe. The payload (word bits DATA_W-1:0) is on `pnl_dout` with `pnl_doe` high while the strobe is low.
- R6: Status bit 1 (address 4) reads 1 for exactly SETUP_CYC+STROBE_CYC+HOLD_CYC clocks per access and 0 otherwise. While it is 0, both chip selects and both strobes are high.
- R7: A trigger that arrives while the engine is busy is ignored. The running access keeps its panel, payload and length, and no second access follows.
- R8: A write to the read trigger (address 3) with bit 0 set starts a read cycle. The read cycle uses the same phase timing and panel selection, pulses `pnl_rd_n` instead of `pnl_wr_n`, and never drives the bus. `pnl_rs` is bit 24 of the last value written to address 2.
- R9: The panel bus value present in the last strobe clock of a read is captured. Address 2 then returns it in bits 17:0, with bits 31:18 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 3 | Register address (0 word, 1 write trigger, 2 read data, 3 read trigger, 4 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pnl_cs_n | output | 2 | Chip selects, bit 0 main panel, bit 1 sub panel, active low |
| pnl_rs | output | 1 | Register select, 0 index, 1 data |
| pnl_wr_n | output | 1 | Write strobe, active low |
| pnl_rd_n | output | 1 | Read strobe, active low |
| pnl_dout | output | DATA_W | Bus data driven to the panel |
| pnl_doe | output | 1 | Bus output enable |
| pnl_din | input | DATA_W | Bus data from the panel |

## Verification
The bench sweeps both panels, both register-select values and payloads with all-zero, all-one and alternating bit patterns. It counts, clock by clock, how long the chip select is low before, during and after each strobe. If a phase counter were off by one, the busy length or the strobe position would move. If the payload or the chip select decode were wrong, the sampled bus value or the idle chip select would show it.

A trigger with an invalid word, and a trigger with its go bit clear, must leave every pin quiet. A second trigger injected mid-transfer with the other panel selected must not change or extend the access. A design without the busy guard would switch panels or start a second cycle.

Reads drive the bus only during the read strobe. A capture taken at the wrong clock would return zero, and a mask or width error would leave upper bits set.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD} pbus_state_e;

  localparam int ADDR_W      = 3;
  localparam int REG_W       = 32;
  localparam int RD_W        = 18;

  localparam logic [ADDR_W-1:0] A_WORD  = 3'd0;
  localparam logic [ADDR_W-1:0] A_WTRIG = 3'd1;
  localparam logic [ADDR_W-1:0] A_RDATA = 3'd2;
  localparam logic [ADDR_W-1:0] A_RTRIG = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT  = 3'd4;

  localparam int VALID_BIT   = 28;
  localparam int KIND_BIT    = 24;
  localparam int GO_BIT      = 0;
  localparam int SUB_BIT     = 1;
  localparam int BUSY_BIT    = 1;
endpackage

// File: rtl/pbus_regs.sv
module pbus_regs
  import pbus_pkg::*;
#(
  parameter int DATA_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] cap_data,
  output logic              go,
  output logic              go_rd,
  output logic              go_sub,
  output logic              go_rs,
  output logic [DATA_W-1:0] go_payload,
  output logic [REG_W-1:0]  rdata
);
  localparam int PAD_W = REG_W - RD_W;

  logic [REG_W-1:0] word_q;
  logic             rd_kind_q;
  logic [RD_W-1:0]  cap_q;
  logic             wr_go, rd_go;

  assign wr_go = we && (addr == A_WTRIG) && wdata[GO_BIT] && word_q[VALID_BIT] && !busy;
  assign rd_go = we && (addr == A_RTRIG) && wdata[GO_BIT] && !busy;

  assign go         = wr_go || rd_go;
  assign go_rd      = rd_go;
  assign go_sub     = wdata[SUB_BIT];
  assign go_rs      = rd_go ? rd_kind_q : word_q[KIND_BIT];
  assign go_payload = word_q[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q    <= '0;
      rd_kind_q <= 1'b0;
      cap_q     <= '0;
    end else begin
      if (we && addr == A_WORD)  word_q    <= wdata;
      if (we && addr == A_RDATA) rd_kind_q <= wdata[KIND_BIT];
      if (cap_en)                cap_q     <= RD_W'(cap_data);
    end
  end

  always_comb begin
    case (addr)
      A_WORD:  rdata = word_q;
      A_RDATA: rdata = {{PAD_W{1'b0}}, cap_q};
      A_STAT:  rdata = REG_W'({busy, 1'b0});
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
  import pbus_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              go_rd,
  input  logic              go_sub,
  input  logic              go_rs,
  input  logic [DATA_W-1:0] go_payload,
  input  logic [DATA_W-1:0] bus_in,
  output logic [1:0]        cs_n,
  output logic              rs,
  output logic              wr_n,
  output logic              rd_n,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              busy,
  output logic              cap_en,
  output logic [DATA_W-1:0] cap_data
);
  localparam int MAX_A = (SETUP_CYC > STROBE_CYC) ? SETUP_CYC : STROBE_CYC;
  localparam int MAX_L = (MAX_A > HOLD_CYC) ? MAX_A : HOLD_CYC;
  localparam int CNT_W = (MAX_L > 1) ? $clog2(MAX_L) : 1;

  pbus_state_e       state, nstate;
  logic [CNT_W-1:0]  cnt, ncnt;
  logic              rd_q, sub_q, rs_q;
  logic [DATA_W-1:0] pay_q;
  logic              rd_nx, sub_nx, rs_nx;
  logic [DATA_W-1:0] pay_nx;
  logic              take;

  assign take   = (state == ST_IDLE) && go;
  assign rd_nx  = take ? go_rd      : rd_q;
  assign sub_nx = take ? go_sub     : sub_q;
  assign rs_nx  = take ? go_rs      : rs_q;
  assign pay_nx = take ? go_payload : pay_q;

  always_comb begin
    nstate = state;
    ncnt   = cnt;
    case (state)
      ST_IDLE:
        if (go) begin
          nstate = ST_SETUP;
          ncnt   = CNT_W'(SETUP_CYC - 1);
        end
      ST_SETUP:
        if (cnt == '0) begin
          nstate = ST_STROBE;
          ncnt   = CNT_W'(STROBE_CYC - 1);
        end else ncnt = cnt - CNT_W'(1);
      ST_STROBE:
        if (cnt == '0) begin
          nstate = ST_HOLD;
          ncnt   = CNT_W'(HOLD_CYC - 1);
        end else ncnt = cnt - CNT_W'(1);
      default:
        if (cnt == '0) nstate = ST_IDLE;
        else ncnt = cnt - CNT_W'(1);
    endcase
  end

  assign cap_en   = (state == ST_STROBE) && (cnt == '0) && rd_q;
  assign cap_data = bus_in;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      rd_q    <= 1'b0;
      sub_q   <= 1'b0;
      rs_q    <= 1'b0;
      pay_q   <= '0;
      cs_n    <= 2'b11;
      rs      <= 1'b0;
      wr_n    <= 1'b1;
      rd_n    <= 1'b1;
      bus_out <= '0;
      bus_oe  <= 1'b0;
      busy    <= 1'b0;
    end else begin
      state   <= nstate;
      cnt     <= ncnt;
      rd_q    <= rd_nx;
      sub_q   <= sub_nx;
      rs_q    <= rs_nx;
      pay_q   <= pay_nx;
      busy    <= (nstate != ST_IDLE);
      cs_n    <= (nstate == ST_IDLE) ? 2'b11 : (sub_nx ? 2'b01 : 2'b10);
      rs      <= (nstate == ST_IDLE) ? 1'b0 : rs_nx;
      wr_n    <= !((nstate == ST_STROBE) && !rd_nx);
      rd_n    <= !((nstate == ST_STROBE) && rd_nx);
      bus_oe  <= (nstate != ST_IDLE) && !rd_nx;
      bus_out <= ((nstate != ST_IDLE) && !rd_nx) ? pay_nx : '0;
    end
  end
endmodule

// File: rtl/pbus_cmd_engine.sv
module pbus_cmd_engine
  import pbus_pkg::*;
#(
  parameter int DATA_W     = 18,
  parameter int SETUP_CYC  = 2,
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [1:0]        pnl_cs_n,
  output logic              pnl_rs,
  output logic              pnl_wr_n,
  output logic              pnl_rd_n,
  output logic [DATA_W-1:0] pnl_dout,
  output logic              pnl_doe,
  input  logic [DATA_W-1:0] pnl_din
);
  logic              busy, cap_en;
  logic [DATA_W-1:0] cap_data, go_payload;
  logic              go, go_rd, go_sub, go_rs;

  pbus_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .cap_en(cap_en), .cap_data(cap_data),
    .go(go), .go_rd(go_rd), .go_sub(go_sub), .go_rs(go_rs),
    .go_payload(go_payload), .rdata(reg_rdata)
  );

  pbus_seq #(
    .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC),
    .STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC)
  ) u_seq (
    .clk(clk), .rst(rst), .go(go), .go_rd(go_rd), .go_sub(go_sub),
    .go_rs(go_rs), .go_payload(go_payload), .bus_in(pnl_din),
    .cs_n(pnl_cs_n), .rs(pnl_rs), .wr_n(pnl_wr_n), .rd_n(pnl_rd_n),
    .bus_out(pnl_dout), .bus_oe(pnl_doe), .busy(busy),
    .cap_en(cap_en), .cap_data(cap_data)
  );
endmodule

// File: rtl/pbus_cmd_engine_chk.sv
module pbus_cmd_engine_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cs_n,
  input logic       rs,
  input logic       wr_n,
  input logic       rd_n,
  input logic       doe,
  input logic       busy
);
  AST_ONE_PANEL: assert property (@(posedge clk) disable iff (rst)
    $countones(~cs_n) <= 1); // R3
  AST_RS_STEADY: assert property (@(posedge clk) disable iff (rst)
    (cs_n != 2'b11 && $past(cs_n) != 2'b11) |-> $stable(rs)); // R4
  AST_STROBE_IN_CS: assert property (@(posedge clk) disable iff (rst)
    (!wr_n || !rd_n) |-> (cs_n != 2'b11)); // R5
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n == 2'b11 && wr_n && rd_n)); // R6
  AST_BUSY_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(cs_n)); // R7
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> (!doe && wr_n)); // R8
endmodule

bind pbus_cmd_engine pbus_cmd_engine_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(pnl_cs_n), .rs(pnl_rs), .wr_n(pnl_wr_n),
  .rd_n(pnl_rd_n), .doe(pnl_doe), .busy(busy)
);

// File: tb/pbus_cmd_engine_tb.sv
module pbus_cmd_engine_tb;
  localparam int DW = 18, S = 2, P = 3, H = 1;
  localparam int TOT = S + P + H;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0] pnl_cs_n;
  logic pnl_rs, pnl_wr_n, pnl_rd_n, pnl_doe;
  logic [DW-1:0] pnl_dout, pnl_din, rd_val = '0;
  int errors = 0, checks = 0, cyc = 0;

  assign pnl_din = pnl_rd_n ? '0 : rd_val;

  always #2 clk = ~clk;

  pbus_cmd_engine #(.DATA_W(DW), .SETUP_CYC(S), .STROBE_CYC(P), .HOLD_CYC(H)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pnl_cs_n(pnl_cs_n), .pnl_rs(pnl_rs), .pnl_wr_n(pnl_wr_n),
    .pnl_rd_n(pnl_rd_n), .pnl_dout(pnl_dout), .pnl_doe(pnl_doe), .pnl_din(pnl_din)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog expired actual=%0d expected<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Called right after the trigger write; watches one access cycle by cycle.
  task automatic watch(input bit sub, input bit is_rd, input bit exp_rs,
                       input logic [DW-1:0] pay, input bit inj);
    int n = 0, strb = 0, first = -1, other = 0, selhi = 0, rsbad = 0, bad = 0, wrong = 0;
    while (n < 40) begin
      reg_we = 1'b0; reg_addr = 3'd4;
      #1;
      if (!reg_rdata[1]) break;
      if (pnl_cs_n[sub ? 0 : 1] == 1'b0) other++;
      if (pnl_cs_n[sub ? 1 : 0] == 1'b1) selhi++;
      if (pnl_rs !== exp_rs) rsbad++;
      if (is_rd ? !pnl_wr_n : !pnl_rd_n) wrong++;
      if (is_rd ? !pnl_rd_n : !pnl_wr_n) begin
        strb++;
        if (first < 0) first = n;
        if (!is_rd && (pnl_dout !== pay || !pnl_doe)) bad++;
        if (is_rd && pnl_doe) bad++;
      end
      if (inj && n == 1) begin
        reg_addr = 3'd1; reg_wdata = sub ? 32'h1 : 32'h3; reg_we = 1'b1;
      end
      n++;
      @(negedge clk);
    end
    chk(n == TOT, "R6 busy length", n, TOT);
    chk(strb == P && wrong == 0, "R5/R8 strobe length", strb, P);
    chk(first == S, "R5 setup before strobe", first, S);
    chk(other == 0 && selhi == 0, "R3 panel select", other + selhi, 0);
    chk(rsbad == 0, "R4 register select", rsbad, 0);
    chk(bad == 0, is_rd ? "R8 bus not driven" : "R5 payload on bus", bad, 0);
    chk(pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n, "R6 idle after access", pnl_cs_n, 3);
  endtask

  task automatic quiet(input string req, input int len);
    int act = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      reg_addr = 3'd4;
      #1;
      if (pnl_cs_n != 2'b11 || !pnl_wr_n || !pnl_rd_n || reg_rdata[1]) act++;
    end
    chk(act == 0, req, act, 0);
  endtask

  initial begin
    logic [31:0] d;
    logic [DW-1:0] pats [6];
    pats[0] = 18'h00000; pats[1] = 18'h3FFFF; pats[2] = 18'h2AAAA;
    pats[3] = 18'h15555; pats[4] = 18'h00001; pats[5] = 18'h20000;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd4, d);
    chk(pnl_cs_n == 2'b11 && pnl_wr_n && pnl_rd_n && !pnl_doe && d[1] == 1'b0,
        "R1 reset pins/status", {pnl_cs_n, pnl_wr_n, pnl_rd_n, pnl_doe, d[1]}, 6'b111100);
    rd(3'd2, d);
    chk(d == 0, "R1 read data reset", d, 0);

    // R2 invalid word ignored
    wr(3'd0, 32'h0100_1234);
    wr(3'd1, 32'h1);
    quiet("R2 invalid word ignored", 10);
    // R3 trigger with go bit clear ignored
    wr(3'd0, 32'h1000_1234);
    wr(3'd1, 32'h2);
    quiet("R3 trigger without go ignored", 10);

    // R3/R4/R5/R6 write sweep
    for (int sub = 0; sub < 2; sub++)
      for (int kind = 0; kind < 2; kind++)
        for (int p = 0; p < 6; p++) begin
          wr(3'd0, 32'h1000_0000 | (32'(kind) << 24) | 32'(pats[p]));
          wr(3'd1, 32'h1 | (32'(sub) << 1));
          watch(sub[0], 1'b0, kind[0], pats[p], 1'b0);
        end

    // R7 trigger while busy ignored
    wr(3'd0, 32'h1100_0ABC);
    wr(3'd1, 32'h1);
    watch(1'b0, 1'b0, 1'b1, 18'h00ABC, 1'b1);
    quiet("R7 no second access", 8);
    wr(3'd0, 32'h1000_0055);
    wr(3'd1, 32'h3);
    watch(1'b1, 1'b0, 1'b0, 18'h00055, 1'b1);
    quiet("R7 no second access sub", 8);

    // R8/R9 read sweep
    for (int sub = 0; sub < 2; sub++)
      for (int kind = 0; kind < 2; kind++)
        for (int p = 1; p < 5; p++) begin
          rd_val = pats[p] ^ DW'(sub * 3 + kind);
          wr(3'd2, 32'(kind) << 24);
          wr(3'd3, 32'h1 | (32'(sub) << 1));
          watch(sub[0], 1'b1, kind[0], '0, 1'b0);
          rd(3'd2, d);
          chk(d == {14'd0, rd_val}, "R9 read data captured", d, {14'd0, rd_val});
        end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule